// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt requests from 32 primary sources and 32 secondary peripheral sources and presents one CPU interrupt line plus a vector number for the request that should be serviced first. Each level has a raw status register, a mask register and a fixed per-bit choice between latched edge capture and transparent level following. The secondary level does not reach the CPU directly. Its masked requests are merged into three group lines, and those lines drive three fixed primary status bits.

The vector resolves through both levels. The lowest pending primary bit wins. If the winner is one of the three group bits, the vector becomes the lowest pending secondary bit instead, offset into a separate range. Software programs the masks and clears latched edges through a four-word register port. The port has a single write strobe and a combinational read.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, both mask registers and every latched edge bit read as 0, `cpu_irq_o` and `vec_valid_o` are low, and `vec_o` is 0.
- R2: Primary level bits follow `prim_src_i` in the same cycle when read back at register address 1. The level bits are every bit except 4–6 and the edge set.
- R3: Primary edge bits 16–19, 22–24 and 28–30 set one clock after a rising input and stay set after the input falls.
- R4: A write to address 1 clears each primary edge bit whose data bit is 0 and keeps each one whose data bit is 1. An edge that arrives in the same cycle as its clear still ends up set.
- R5: Secondary edge bits 16, 22 and 28 latch rising edges of `sec_src_i`, and a write to address 3 with the bit at 0 clears them. Every other secondary bit follows its input.
- R6: Primary bit 4 is set exactly when a masked secondary bit in 16–31 is pending, bit 5 when one in 8–15 is, and bit 6 when one in 0–7 is. `prim_src_i[6:4]` has no effect.
- R7: Pending is status AND mask at each level. `cpu_irq_o` is high exactly when any primary bit is pending.
- R8: When the lowest pending primary bit is not 4–6, `vec_o` equals its index + 1 (range 1–32).
- R9: When the lowest pending primary bit is 4, 5 or 6, `vec_o` equals the lowest pending secondary bit index + 33 (range 33–64).
- R10: With nothing pending, `vec_valid_o` is low and `vec_o` is 0. Otherwise `vec_valid_o` is high.
- R11: Register map: address 0 is the primary mask, 1 the primary status, 2 the secondary mask and 3 the secondary status. Mask writes take effect on the next clock and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prim_src_i | input | 32 | Primary interrupt sources |
| sec_src_i | input | 32 | Secondary interrupt sources |
| reg_addr_i | input | 2 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| cpu_irq_o | output | 1 | CPU interrupt request |
| vec_valid_o | output | 1 | Vector is valid |
| vec_o | output | 7 | Vector number of the winning source |

## Verification
Directed cases isolate single sources, one at a time:
- a lone level bit, which checks the 1–32 vector offset;
- a lone edge pulse, which separates latching from following;
- a clear that coincides with a new edge, which separates clear priority from set priority;
- secondary requests under mask changes, which show whether a group line tracks masked or raw secondary status.

A case where a low-numbered primary bit and a group bit are pending together tells the lowest-bit rule apart from a cascade-first rule. Random source patterns run alongside random register writes, and each cycle is compared with a bench model. This exercises mixtures of edge and level bits, overlapping groups, and clears landing on live edges.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned SRC_W = 32;
  localparam int unsigned VEC_W = 7;
  localparam logic [SRC_W-1:0] PRIM_EDGE = 32'h71CF_0000;
  localparam logic [SRC_W-1:0] SEC_EDGE  = 32'h1041_0000;
  localparam int unsigned GRP_IO_BIT    = 4;
  localparam int unsigned GRP_MISC_BIT  = 5;
  localparam int unsigned GRP_AUDIO_BIT = 6;
  localparam int unsigned SEC_VEC_BASE  = 33;

  typedef enum logic [1:0] {
    REG_PRIM_MASK = 2'd0,
    REG_PRIM_STAT = 2'd1,
    REG_SEC_MASK  = 2'd2,
    REG_SEC_STAT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] EDGE_BITS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_keep_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, edge_q, clr_bits, rise;

  assign clr_bits = clr_we_i ? ~clr_keep_i : '0;
  assign rise     = src_i & ~prev_q & EDGE_BITS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= src_i;
      // new edge wins over a same-cycle clear
      edge_q <= ((edge_q & ~clr_bits) | rise) & EDGE_BITS;
    end
  end

  assign status_o = edge_q | (src_i & ~EDGE_BITS);

  assert_edge_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((edge_q & $past(edge_q & ~clr_bits)) == $past(edge_q & ~clr_bits)));
  assert_edge_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((edge_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_ffs.sv
module irq_ffs #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] prim_src_i,
  input  logic [SRC_W-1:0] sec_src_i,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_we_i,
  input  logic [SRC_W-1:0] reg_wdata_i,
  output logic [SRC_W-1:0] reg_rdata_o,
  output logic             cpu_irq_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned IW = $clog2(SRC_W);

  logic [SRC_W-1:0] prim_mask_q, sec_mask_q;
  logic [SRC_W-1:0] prim_stat, sec_stat, prim_pend, sec_pend, prim_in;
  logic [2:0]       grp_req;
  logic             prim_hit, sec_hit;
  logic [IW-1:0]    prim_idx, sec_idx;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_mask_q <= '0;
      sec_mask_q  <= '0;
    end else if (reg_we_i) begin
      if (sel == REG_PRIM_MASK) prim_mask_q <= reg_wdata_i;
      if (sel == REG_SEC_MASK)  sec_mask_q  <= reg_wdata_i;
    end
  end

  irq_src_capture #(.W(SRC_W), .EDGE_BITS(SEC_EDGE)) u_sec_cap (
    .clk_i, .rst_ni,
    .src_i      (sec_src_i),
    .clr_we_i   (reg_we_i && sel == REG_SEC_STAT),
    .clr_keep_i (reg_wdata_i),
    .status_o   (sec_stat)
  );

  assign sec_pend = sec_stat & sec_mask_q;
  assign grp_req[0] = |sec_pend[31:16];
  assign grp_req[1] = |sec_pend[15:8];
  assign grp_req[2] = |sec_pend[7:0];

  always_comb begin
    prim_in = prim_src_i;
    prim_in[GRP_IO_BIT]    = grp_req[0];
    prim_in[GRP_MISC_BIT]  = grp_req[1];
    prim_in[GRP_AUDIO_BIT] = grp_req[2];
  end

  irq_src_capture #(.W(SRC_W), .EDGE_BITS(PRIM_EDGE)) u_prim_cap (
    .clk_i, .rst_ni,
    .src_i      (prim_in),
    .clr_we_i   (reg_we_i && sel == REG_PRIM_STAT),
    .clr_keep_i (reg_wdata_i),
    .status_o   (prim_stat)
  );

  assign prim_pend = prim_stat & prim_mask_q;

  irq_ffs #(.W(SRC_W)) u_prim_ffs (.req_i(prim_pend), .found_o(prim_hit), .idx_o(prim_idx));
  irq_ffs #(.W(SRC_W)) u_sec_ffs  (.req_i(sec_pend),  .found_o(sec_hit),  .idx_o(sec_idx));

  always_comb begin
    vec_o = '0;
    if (prim_hit) begin
      if (prim_idx >= IW'(GRP_IO_BIT) && prim_idx <= IW'(GRP_AUDIO_BIT))
        vec_o = VEC_W'(sec_idx) + VEC_W'(SEC_VEC_BASE);
      else
        vec_o = VEC_W'(prim_idx) + VEC_W'(1);
    end
  end

  assign cpu_irq_o   = |prim_pend;
  assign vec_valid_o = prim_hit;

  always_comb begin
    unique case (sel)
      REG_PRIM_MASK: reg_rdata_o = prim_mask_q;
      REG_PRIM_STAT: reg_rdata_o = prim_stat;
      REG_SEC_MASK:  reg_rdata_o = sec_mask_q;
      default:       reg_rdata_o = sec_stat;
    endcase
  end

  assert_idle_vec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (vec_o == '0));
  assert_no_group_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o < VEC_W'(GRP_IO_BIT + 1) || vec_o > VEC_W'(GRP_AUDIO_BIT + 1)));
  assert_cascade_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o >= VEC_W'(SEC_VEC_BASE)) |-> (sec_hit && (|prim_pend[GRP_AUDIO_BIT:GRP_IO_BIT])));
  assert_irq_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |-> (vec_o != '0));
endmodule

// File: tb/tb_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module tb_irq_cascade_ctrl;
  localparam logic [31:0] PE = 32'h71CF_0000;
  localparam logic [31:0] SE = 32'h1041_0000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] prim_src = '0, sec_src = '0, wdata = '0, rdata;
  logic [1:0]  addr = '0;
  logic        we = 1'b0, cpu_irq, vvalid;
  logic [6:0]  vec;

  int checks = 0, failures = 0, cycles = 0;
  logic [31:0] m_pmask, m_smask, m_plat, m_slat, m_pprev, m_sprev;

  always #10 clk = ~clk;

  irq_cascade_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .prim_src_i(prim_src), .sec_src_i(sec_src),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_irq_o(cpu_irq), .vec_valid_o(vvalid), .vec_o(vec)
  );

  function automatic logic [31:0] e_sstat();
    return m_slat | (sec_src & ~SE);
  endfunction
  function automatic logic [31:0] e_spend();
    return e_sstat() & m_smask;
  endfunction
  function automatic logic [31:0] e_pin();
    logic [31:0] p, sp;
    sp = e_spend();
    p = prim_src;
    p[4] = |sp[31:16];
    p[5] = |sp[15:8];
    p[6] = |sp[7:0];
    return p;
  endfunction
  function automatic logic [31:0] e_pstat();
    return m_plat | (e_pin() & ~PE);
  endfunction
  function automatic int ffs(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction
  function automatic logic [6:0] e_vec();
    int p;
    p = ffs(e_pstat() & m_pmask);
    if (p < 0) return 7'd0;
    if (p >= 4 && p <= 6) return 7'(ffs(e_spend()) + 33);
    return 7'(p + 1);
  endfunction
  function automatic logic [31:0] e_rdata();
    case (addr)
      2'd0: return m_pmask;
      2'd1: return e_pstat();
      2'd2: return m_smask;
      default: return e_sstat();
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag);
    chk({tag, " R8 R9 vec"}, 32'(vec), 32'(e_vec()));
    chk({tag, " R10 valid"}, 32'(vvalid), 32'(e_vec() != 0));
    chk({tag, " R7 irq"}, 32'(cpu_irq), 32'(|(e_pstat() & m_pmask)));
    chk({tag, " R11 rdata"}, rdata, e_rdata());
  endtask

  task automatic tick();
    logic [31:0] pin, pclr, sclr, npl, nsl;
    pin  = e_pin();
    pclr = (we && addr == 2'd1) ? ~wdata : '0;
    sclr = (we && addr == 2'd3) ? ~wdata : '0;
    npl  = ((m_plat & ~pclr) | (pin & ~m_pprev)) & PE;
    nsl  = ((m_slat & ~sclr) | (sec_src & ~m_sprev)) & SE;
    @(posedge clk);
    m_pprev = pin; m_sprev = sec_src; m_plat = npl; m_slat = nsl;
    if (we && addr == 2'd0) m_pmask = wdata;
    if (we && addr == 2'd2) m_smask = wdata;
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a);
    addr = a; #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(1234));
    m_pmask = '0; m_smask = '0; m_plat = '0; m_slat = '0; m_pprev = '0; m_sprev = '0;
    #45 rst_ni = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a)); chk("R1 reset reg", rdata, 32'h0); end
    chk("R1 reset irq", 32'(cpu_irq), 0);
    chk("R1 reset vec", 32'(vec), 0);
    chk("R11 mask reg", 32'(vvalid), 0);

    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0); chk("R11 prim mask readback", rdata, 32'hFFFF_FFFF);
    // R2 level follows same cycle
    prim_src = 32'h0000_0100; rd(2'd1);
    chk("R2 level status", rdata, 32'h0000_0100);
    chk("R8 vec level", 32'(vec), 32'd9);
    prim_src = 32'h0000_0000; #1;
    chk("R2 level drop", rdata, 32'h0);
    // R3 edge latch on bit 17
    prim_src[17] = 1'b1; #1;
    chk("R3 edge not yet", rdata, 32'h0);
    tick(); prim_src[17] = 1'b0; tick();
    chk("R3 edge held", rdata, 32'h0002_0000);
    chk("R8 vec edge", 32'(vec), 32'd18);
    // R4 keep with 1, clear with 0
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1); chk("R4 keep", rdata, 32'h0002_0000);
    wr(2'd1, 32'hFFFD_FFFF); rd(2'd1); chk("R4 clear", rdata, 32'h0);
    // R4 edge coinciding with clear stays
    prim_src[28] = 1'b1;
    wr(2'd1, 32'h0); prim_src[28] = 1'b0; rd(2'd1);
    chk("R4 edge beats clear", rdata, 32'h1000_0000);
    wr(2'd1, 32'h0);
    // R6 ignored inputs and groups
    prim_src = 32'h0000_0070; rd(2'd1);
    chk("R6 ignored prim bits", rdata, 32'h0);
    chk("R10 idle vec", 32'(vec), 0);
    sec_src = 32'h0000_0200; #1;
    chk("R6 unmasked sec no group", rdata, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd1);
    chk("R6 misc group bit", rdata, 32'h0000_0020);
    chk("R9 cascade vec", 32'(vec), 32'd42);
    prim_src = 32'h0000_0009; #1;
    chk("R8 lower primary wins", 32'(vec), 32'd1);
    prim_src = 32'h0; sec_src = 32'h0; #1;
    // R5 secondary edge bit 22
    sec_src[22] = 1'b1; tick(); sec_src[22] = 1'b0; tick(); rd(2'd3);
    chk("R5 sec edge held", rdata, 32'h0040_0000);
    chk("R9 sec edge vec", 32'(vec), 32'd55);
    wr(2'd3, 32'hFFBF_FFFF); rd(2'd3);
    chk("R5 sec clear", rdata, 32'h0);
    chk_out("R10 after clear");

    for (int n = 0; n < 2000; n++) begin
      prim_src = $urandom() & $urandom();
      sec_src  = $urandom() & $urandom() & $urandom();
      addr = 2'($urandom());
      wdata = ($urandom_range(0, 3) == 0) ? $urandom() : ~($urandom() & $urandom());
      we = ($urandom_range(0, 3) == 0);
      tick();
      we = 1'b0;
      chk_out("rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule